// File: doc/BRIEF.md
# Qualified Edge Interrupt Latch

The block watches a small group of asynchronous digital input lines and turns chosen transitions on them into one interrupt request. Each raw line is first brought into the clock domain by a synchroniser. A single global inversion setting can then flip every line, so that an open or low input reads as 1 instead of 0. Each line has its own enable bit and its own edge-direction bit. A transition counts only when its line is enabled and the transition goes the way that line's direction bit asks for.

Each counted transition sets a sticky per-line flag. When the interrupt enable is set, it also sets a single interrupt flip-flop. That flip-flop stays set until a clear strobe arrives. The clear strobe also empties every flag, and any edge arriving in the same cycle as the clear is dropped. A read strobe, given when software reads the flags, empties the flags alone. The synchronised, inversion-adjusted line levels are also presented for readback.

Top module: `edge_irq_latch`

## Requirements
- R1: A change on `line_raw` appears on `line_state` at the third rising clock edge after it, and `line_state` equals the synchronised input XOR `invert_in` (applied to every line).
- R2: With `invert_in` = 0 a low input reads as 0 on `line_state`. With `invert_in` = 1 it reads as 1, and a high input reads as 0.
- R3: A line's flag in `edge_flags` is set only by an edge of the inversion-adjusted level on a line whose `edge_en` bit is 1. `edge_pol` bit 1 selects rising (0 to 1) and bit 0 selects falling (1 to 0). Edges of the other direction, and edges on disabled lines, leave flags and `irq` unchanged.
- R4: Flags are sticky: a set flag stays 1 until a read or clear strobe. Several lines can be flagged at once, and each line holds a single bit, however many edges it sees.
- R5: A one-cycle `stat_rd` clears `edge_flags` at the following clock edge, except for lines that have a qualifying edge in that same cycle, which stay set. `stat_rd` never changes `irq`.
- R6: Once `irq` is 1 it stays 1 through further edges, reads and changes of `irq_en`, until `irq_clr`.
- R7: A one-cycle `irq_clr` clears both `edge_flags` and `irq` at the next clock edge. A qualifying edge in the same cycle as the clear is lost and is not reported afterwards.
- R8: During reset `line_state`, `edge_flags` and `irq` are 0. For the first SYNC_STAGES+1 clock edges after reset is released no edge is reported, whatever the inputs hold.
- R9: With `irq_en` = 0 a qualifying edge still sets its flag but does not set `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_raw | input | NLINES | Asynchronous raw input lines |
| invert_in | input | 1 | Global inversion applied to all lines after synchronisation |
| edge_en | input | NLINES | Per-line edge detection enable |
| edge_pol | input | NLINES | Per-line direction: 1 rising, 0 falling |
| irq_en | input | 1 | Allows qualifying edges to set the interrupt flip-flop |
| stat_rd | input | 1 | One-cycle strobe marking a read of the flags |
| irq_clr | input | 1 | One-cycle strobe clearing flags and interrupt |
| line_state | output | NLINES | Synchronised, inversion-adjusted line levels |
| edge_flags | output | NLINES | Sticky per-line edge flags |
| irq | output | 1 | Interrupt request |

## Verification
The checker treats `line_raw` as fully asynchronous. It assumes that `edge_en`, `edge_pol`, `irq_en` and the strobes are driven to known values from time zero and that reset is held from the first edge, since its rules compare each cycle with the one before. The stimulus changes every input on the falling clock edge and holds reset from the start. It never flips `invert_in` and a raw line in the same step, so each step produces at most one level change per line and the expected flags stay unambiguous.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam logic POL_FALL = 1'b0;
  localparam logic POL_RISE = 1'b1;

  // True when a level step from prev to cur matches the requested direction.
  function automatic logic edge_match(input logic prev, input logic cur, input logic pol);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    return (pol == POL_RISE) ? rise : fall;
  endfunction
endpackage

// File: rtl/eil_sync.sv
module eil_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eil_qualify.sv
module eil_qualify
  import edge_irq_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_in,
  input  logic             invert,
  input  logic [WIDTH-1:0] en,
  input  logic [WIDTH-1:0] pol,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] hit
);
  localparam int WARM = STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);
  localparam logic [CW-1:0] WARM_MAX = CW'(WARM);

  logic [WIDTH-1:0] cond;
  logic [WIDTH-1:0] prev;
  logic [CW-1:0]    warm_cnt;
  logic             armed;

  assign cond  = sync_in ^ {WIDTH{invert}};
  assign armed = (warm_cnt == WARM_MAX);
  assign level = prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev     <= '0;
      warm_cnt <= '0;
    end else begin
      prev <= cond;
      if (!armed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_line
      assign hit[i] = armed & en[i] & edge_match(prev[i], cond[i], pol[i]);
    end
  endgenerate
endmodule

// File: rtl/eil_latch.sv
module eil_latch #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hit,
  input  logic             irq_en,
  input  logic             rd,
  input  logic             clr,
  output logic [WIDTH-1:0] flags,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else if (clr) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (rd ? '0 : flags) | hit;
      if (irq_en && (|hit)) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/edge_irq_latch.sv
module edge_irq_latch #(
  parameter int NLINES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] line_raw,
  input  logic              invert_in,
  input  logic [NLINES-1:0] edge_en,
  input  logic [NLINES-1:0] edge_pol,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              irq_clr,
  output logic [NLINES-1:0] line_state,
  output logic [NLINES-1:0] edge_flags,
  output logic              irq
);
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] hit;

  eil_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_raw), .q(synced)
  );

  eil_qualify #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_qual (
    .clk(clk), .rst(rst), .sync_in(synced), .invert(invert_in),
    .en(edge_en), .pol(edge_pol), .level(line_state), .hit(hit)
  );

  eil_latch #(.WIDTH(NLINES)) u_latch (
    .clk(clk), .rst(rst), .hit(hit), .irq_en(irq_en),
    .rd(stat_rd), .clr(irq_clr), .flags(edge_flags), .irq(irq)
  );
endmodule

// File: rtl/edge_irq_latch_checker.sv
module edge_irq_latch_checker #(
  parameter int NLINES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] edge_en,
  input logic              irq_en,
  input logic              stat_rd,
  input logic              irq_clr,
  input logic [NLINES-1:0] edge_flags,
  input logic              irq
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 2);
  localparam logic [CW-1:0] CMAX = CW'(WARM + 1);

  logic [CW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CMAX) since_rst <= since_rst + 1'b1;
  end

  // R8: quiet warm-up window after reset release
  a_r8_warmup_quiet: assert property (@(posedge clk) disable iff (rst)
    (since_rst <= CW'(WARM)) |-> (edge_flags == '0 && !irq));

  // R7: clear empties everything
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> (edge_flags == '0 && !irq));

  // R6: request holds until clear
  a_r6_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);

  // R4: flags only drop on read or clear
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (!stat_rd && !irq_clr) |=> ((edge_flags & $past(edge_flags)) == $past(edge_flags)));

  // R3: a newly set flag needs its line enabled in the previous cycle
  a_r3_enabled_only: assert property (@(posedge clk) disable iff (rst)
    !irq_clr |=> ((edge_flags & ~$past(edge_flags) & ~$past(edge_en)) == '0));

  // R9: request rises only with interrupt enable and a flagged line
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(irq_en) && edge_flags != '0));

  // R5: read leaves the request alone
  a_r5_read_keeps_irq: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !irq_clr && irq) |=> irq);
endmodule

bind edge_irq_latch edge_irq_latch_checker #(.NLINES(NLINES), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .edge_en(edge_en), .irq_en(irq_en), .stat_rd(stat_rd),
  .irq_clr(irq_clr), .edge_flags(edge_flags), .irq(irq)
);

// File: tb/edge_irq_latch_test.sv
module edge_irq_latch_test;
  localparam int NL = 4;
  localparam int NV = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] line_raw = '0;
  logic          invert_in = 1'b0;
  logic [NL-1:0] edge_en = '0;
  logic [NL-1:0] edge_pol = '0;
  logic          irq_en = 1'b0;
  logic          stat_rd = 1'b0;
  logic          irq_clr = 1'b0;
  logic [NL-1:0] line_state;
  logic [NL-1:0] edge_flags;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  edge_irq_latch #(.NLINES(NL), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .line_raw(line_raw), .invert_in(invert_in),
    .edge_en(edge_en), .edge_pol(edge_pol), .irq_en(irq_en),
    .stat_rd(stat_rd), .irq_clr(irq_clr), .line_state(line_state),
    .edge_flags(edge_flags), .irq(irq)
  );

  // {raw, inv, en, pol, ie, op(0 none,1 read,2 clear), exp_state, exp_flags, exp_irq}
  localparam logic [24:0] VEC [NV] = '{
    {4'b0001, 1'b0, 4'b1111, 4'b1111, 1'b1, 2'd1, 4'b0001, 4'b0001, 1'b1},
    {4'b0011, 1'b0, 4'b1111, 4'b1111, 1'b1, 2'd2, 4'b0011, 4'b0010, 1'b1},
    {4'b0001, 1'b0, 4'b1111, 4'b1111, 1'b1, 2'd0, 4'b0001, 4'b0000, 1'b0},
    {4'b0000, 1'b0, 4'b1111, 4'b0000, 1'b1, 2'd2, 4'b0000, 4'b0001, 1'b1},
    {4'b1111, 1'b0, 4'b1100, 4'b0000, 1'b1, 2'd0, 4'b1111, 4'b0000, 1'b0},
    {4'b0000, 1'b0, 4'b1100, 4'b0000, 1'b1, 2'd1, 4'b0000, 4'b1100, 1'b1},
    {4'b1111, 1'b0, 4'b1100, 4'b1111, 1'b0, 2'd2, 4'b1111, 4'b1100, 1'b1},
    {4'b0000, 1'b0, 4'b1111, 4'b0000, 1'b0, 2'd2, 4'b0000, 4'b1111, 1'b0},
    {4'b0000, 1'b1, 4'b1111, 4'b0000, 1'b1, 2'd0, 4'b1111, 4'b0000, 1'b0},
    {4'b0101, 1'b1, 4'b1111, 4'b0000, 1'b1, 2'd2, 4'b1010, 4'b0101, 1'b1},
    {4'b0101, 1'b0, 4'b1111, 4'b0000, 1'b1, 2'd2, 4'b0101, 4'b1010, 1'b1}
  };

  task automatic check(input string req, input string what, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [NL-1:0] raw_v, input logic [NL-1:0] en_v,
                          input logic [NL-1:0] pol_v, input logic ie_v);
    @(negedge clk);
    rst = 1'b1; line_raw = raw_v; edge_en = en_v; edge_pol = pol_v; irq_en = ie_v;
    invert_in = 1'b0; stat_rd = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R8: outputs zero in reset, and warm-up hides the fill of the synchroniser
    do_reset(4'b1111, 4'b1111, 4'b1111, 1'b1);
    check("R8", "state in reset", line_state, 4'b0000);
    check("R8", "flags in reset", edge_flags, 4'b0000);
    check("R8", "irq in reset", {3'b000, irq}, 4'b0000);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check("R8", "flags after warm-up", edge_flags, 4'b0000);
    check("R8", "irq after warm-up", {3'b000, irq}, 4'b0000);
    check("R1", "state after warm-up", line_state, 4'b1111);

    do_reset(4'b0000, 4'b0000, 4'b0000, 1'b0);
    rst = 1'b0;
    repeat (6) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      logic [24:0] v;
      v = VEC[k];
      line_raw = v[24:21]; invert_in = v[20]; edge_en = v[19:16];
      edge_pol = v[15:12]; irq_en = v[11];
      settle();
      check((v[20] ? "R2" : "R1"), $sformatf("vec %0d state", k), line_state, v[8:5]);
      check("R3", $sformatf("vec %0d flags", k), edge_flags, v[4:1]);
      check((v[11] ? "R6" : "R9"), $sformatf("vec %0d irq", k), {3'b000, irq}, {3'b000, v[0]});
      if (v[10:9] == 2'd1) stat_rd = 1'b1;
      if (v[10:9] == 2'd2) irq_clr = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0; irq_clr = 1'b0;
      if (v[10:9] == 2'd1) begin
        check("R5", $sformatf("vec %0d flags after read", k), edge_flags, 4'b0000);
        check("R5", $sformatf("vec %0d irq after read", k), {3'b000, irq}, 4'b0001);
      end
    end

    // R7: clear in the same cycle as a qualifying rising edge on line 1
    edge_pol = 4'b1111;
    @(negedge clk);
    line_raw = 4'b0111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R7", "flags on clear collision", edge_flags, 4'b0000);
    check("R7", "irq on clear collision", {3'b000, irq}, 4'b0000);
    repeat (2) @(negedge clk);
    check("R7", "collided edge lost", edge_flags, 4'b0000);
    check("R1", "state after collision", line_state, 4'b0111);

    // R5: read in the same cycle as a qualifying rising edge on line 3
    line_raw = 4'b1111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R5", "edge kept on read collision", edge_flags, 4'b1000);
    check("R6", "irq set on read collision", {3'b000, irq}, 4'b0001);

    // R4: another edge on an already flagged line keeps one bit, irq held
    line_raw = 4'b0111;
    settle();
    line_raw = 4'b1111;
    settle();
    check("R4", "single bit per line", edge_flags, 4'b1000);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R5", "plain read clears flags", edge_flags, 4'b0000);
    check("R6", "irq held over read", {3'b000, irq}, 4'b0001);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R7", "clear drops irq", {3'b000, irq}, 4'b0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule